// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block is the dependency controller for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory access and writeback. It compares the two source register indices of the instruction in decode with the destination indices of the instructions now in execute and in memory access. From that comparison it decides two things. The first is whether the decode instruction must be held back. The second is where each of its operands should come from once it reaches execute. The choice of operand source is made one stage early and kept in a register, so the execute-stage multiplexers get their selects straight from a flop.

A producer in execute now will sit in the execute/memory latch when the decode instruction reaches execute. A producer in memory access now will then sit in the memory/writeback latch. The register file writes in the first half of a cycle and reads in the second half, so an instruction three or more places behind its producer reads the right value with no help. The `POLICY` parameter sets which latches may feed execute, and the interlock rules change with it. When the controller interlocks, fetch and decode hold and a bubble with no register write enters execute. All pins are plain control signals with no handshake, because the controller is re-evaluated every cycle from the latch contents.

Top module: `hazard_fwd_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both operand selects read 00.
- R2: The operand selects are registered. The value seen during a cycle belongs to the decode inputs sampled at the preceding clock edge. The encoding is 00 = register file, 10 = execute/memory latch, 01 = memory/writeback latch, and 11 never appears.
- R3: A source index of zero never causes an interlock, and its select is always 00.
- R4: A producer whose write enable is low is ignored. It causes no interlock and no bypass.
- R5: When both the execute producer and the memory producer write the register a source needs, the execute producer takes priority. The source is then bypassed from the execute/memory latch (10), or held back if that latch cannot supply it.
- R6: With full bypass (POLICY=3), an ALU result is bypassed at distance one (10) and at distance two (01). A load in execute whose destination is a decode source causes exactly one interlock cycle.
- R7: With execute-latch-only bypass (POLICY=1), a non-load result at distance one is bypassed (10). A load at distance one, or any match at distance two that is not covered by a distance-one bypass, causes an interlock.
- R8: With memory-latch-only bypass (POLICY=2), any match at distance one causes an interlock. A match at distance two is bypassed (01).
- R9: With no bypass (POLICY=0), any match at distance one or two causes an interlock, and the selects always read 00.
- R10: `stall` and `bubble` are always asserted together. An interlock cycle produces 00 selects in the next cycle, because that is the bubble in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | RW | First source index of the decode instruction |
| id_rs2 | input | RW | Second source index of the decode instruction |
| ex_rd | input | RW | Destination index of the instruction in execute |
| ex_wen | input | 1 | Register-write enable of the instruction in execute |
| ex_load | input | 1 | The instruction in execute is a load |
| mem_rd | input | RW | Destination index of the instruction in memory access |
| mem_wen | input | 1 | Register-write enable of the instruction in memory access |
| stall | output | 1 | Hold the program counter and the fetch/decode latch |
| bubble | output | 1 | Load a no-write bubble into the decode/execute latch |
| fwd_a | output | 2 | Execute-stage source select for the first operand |
| fwd_b | output | 2 | Execute-stage source select for the second operand |

## Verification
The assertions assume that the pipeline around the controller tells the truth. In particular, `ex_load` is taken to describe the real execute instruction, and a bubble arrives with its write enable low. They make no assumption about how the indices relate from one cycle to the next. For that reason the stimulus draws every latch field at random each cycle, from indices 0 to 7, so that matches, zero indices and double matches happen often. Directed sequences are added for load-use, double writers and disabled writers. Four instances run side by side, one for each policy, and all of them are checked against one reference function.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    BYP_NONE  = 2'd0,
    BYP_EXMEM = 2'd1,
    BYP_MEMWB = 2'd2,
    BYP_FULL  = 2'd3
  } byp_mode_e;

  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  // register zero is hardwired and never a dependency (R3); writes need wen (R4)
  assign hit = wen && (dst == src) && (src != '0);
endmodule

// File: rtl/hzd_operand.sv
module hzd_operand
  import hzd_pkg::*;
#(
  parameter byp_mode_e POLICY = BYP_FULL,
  parameter int        RW     = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  output logic          need_stall,
  output opnd_src_e     sel
);
  logic hit1, hit2;

  hzd_match #(.RW(RW)) u_m1 (.src(src), .dst(ex_rd),  .wen(ex_wen),  .hit(hit1));
  hzd_match #(.RW(RW)) u_m2 (.src(src), .dst(mem_rd), .wen(mem_wen), .hit(hit2));

  generate
    if (POLICY == BYP_FULL) begin : g_full
      always_comb begin
        need_stall = hit1 && ex_load;
        if (hit1)      sel = SRC_EXMEM;   // younger wins (R5)
        else if (hit2) sel = SRC_MEMWB;
        else           sel = SRC_RF;
      end
    end else if (POLICY == BYP_EXMEM) begin : g_exmem
      always_comb begin
        need_stall = hit1 ? ex_load : hit2;
        sel        = hit1 ? SRC_EXMEM : SRC_RF;
      end
    end else if (POLICY == BYP_MEMWB) begin : g_memwb
      always_comb begin
        need_stall = hit1;
        sel        = (!hit1 && hit2) ? SRC_MEMWB : SRC_RF;
      end
    end else begin : g_none
      always_comb begin
        need_stall = hit1 || hit2;
        sel        = SRC_RF;
      end
    end
  endgenerate
endmodule

// File: rtl/hzd_selreg.sv
module hzd_selreg
  import hzd_pkg::*;
#(
  parameter int NOP = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  opnd_src_e nxt [NOP],
  output opnd_src_e cur [NOP]
);
  generate
    for (genvar i = 0; i < NOP; i++) begin : g_op
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cur[i] <= SRC_RF;
        else if (flush) cur[i] <= SRC_RF;  // bubble carries no bypass
        else            cur[i] <= nxt[i];
      end
    end
  endgenerate
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter byp_mode_e POLICY = BYP_FULL,
  parameter int        RW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  output logic          stall,
  output logic          bubble,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);
  localparam int NOP = 2;

  logic [RW-1:0] src   [NOP];
  logic          op_st [NOP];
  opnd_src_e     nsel  [NOP];
  opnd_src_e     csel  [NOP];
  logic          hold;

  assign src[0] = id_rs1;
  assign src[1] = id_rs2;

  generate
    for (genvar i = 0; i < NOP; i++) begin : g_opnd
      hzd_operand #(.POLICY(POLICY), .RW(RW)) u_op (
        .src(src[i]), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen),
        .need_stall(op_st[i]), .sel(nsel[i])
      );
    end
  endgenerate

  assign hold   = op_st[0] || op_st[1];
  assign stall  = hold;
  assign bubble = hold;

  hzd_selreg #(.NOP(NOP)) u_sel (
    .clk(clk), .rst_n(rst_n), .flush(hold), .nxt(nsel), .cur(csel)
  );

  assign fwd_a = csel[0];
  assign fwd_b = csel[1];
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker
  import hzd_pkg::*;
#(
  parameter byp_mode_e POLICY = BYP_FULL,
  parameter int        RW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] id_rs2,
  input logic [RW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [RW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          stall,
  input logic          bubble,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b
);
  assert_sel_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  assert_zero_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |=> (fwd_a == 2'b00));

  assert_no_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen && !mem_wen) |-> !stall);

  assert_bubble_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fwd_a == 2'b00) && (fwd_b == 2'b00));

  assert_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall == bubble);

  generate
    if (POLICY == BYP_FULL) begin : g_full
      assert_load_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_load && ex_wen));
    end else if (POLICY == BYP_NONE) begin : g_none
      assert_no_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == 2'b00) && (fwd_b == 2'b00));
    end else if (POLICY == BYP_MEMWB) begin : g_memwb
      assert_no_exmem_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b10) && (fwd_b != 2'b10));
    end else begin : g_exmem
      assert_no_memwb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b01) && (fwd_b != 2'b01));
    end
  endgenerate
endmodule

bind hazard_fwd_unit hzd_checker #(.POLICY(POLICY), .RW(RW)) chk (.*);

// File: tb/hazard_fwd_unit_test.sv
`timescale 1ns/1ps
module hazard_fwd_unit_test;
  import hzd_pkg::*;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0;
  logic       st [4];
  logic       bb [4];
  logic [1:0] fa [4];
  logic [1:0] fb [4];
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  hazard_fwd_unit #(.POLICY(BYP_FULL), .RW(RW)) uut (
    .clk, .rst_n, .id_rs1, .id_rs2, .ex_rd, .ex_wen, .ex_load, .mem_rd, .mem_wen,
    .stall(st[3]), .bubble(bb[3]), .fwd_a(fa[3]), .fwd_b(fb[3]));
  hazard_fwd_unit #(.POLICY(BYP_MEMWB), .RW(RW)) uut_mem (
    .clk, .rst_n, .id_rs1, .id_rs2, .ex_rd, .ex_wen, .ex_load, .mem_rd, .mem_wen,
    .stall(st[2]), .bubble(bb[2]), .fwd_a(fa[2]), .fwd_b(fb[2]));
  hazard_fwd_unit #(.POLICY(BYP_EXMEM), .RW(RW)) uut_ex (
    .clk, .rst_n, .id_rs1, .id_rs2, .ex_rd, .ex_wen, .ex_load, .mem_rd, .mem_wen,
    .stall(st[1]), .bubble(bb[1]), .fwd_a(fa[1]), .fwd_b(fb[1]));
  hazard_fwd_unit #(.POLICY(BYP_NONE), .RW(RW)) uut_none (
    .clk, .rst_n, .id_rs1, .id_rs2, .ex_rd, .ex_wen, .ex_load, .mem_rd, .mem_wen,
    .stall(st[0]), .bubble(bb[0]), .fwd_a(fa[0]), .fwd_b(fb[0]));

  // reference: returns {stall, select}
  function automatic logic [2:0] ref_op(int pol, logic [RW-1:0] s);
    logic h1, h2;
    h1 = ex_wen && ex_rd == s && s != 0;
    h2 = mem_wen && mem_rd == s && s != 0;
    case (pol)
      3: return {h1 && ex_load, h1 ? 2'b10 : (h2 ? 2'b01 : 2'b00)};
      1: return {h1 ? ex_load : h2, h1 ? 2'b10 : 2'b00};
      2: return {h1, (!h1 && h2) ? 2'b01 : 2'b00};
      default: return {h1 || h2, 2'b00};
    endcase
  endfunction

  task automatic chk(bit ok, string req, int pol, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s policy=%0d actual=%0h expected=%0h", req, pol, act, exp);
    end
  endtask

  // drive at negedge, check stall now, check selects after the next edge
  task automatic step(string req, logic [RW-1:0] a, logic [RW-1:0] b,
                      logic [RW-1:0] erd, logic ew, logic el,
                      logic [RW-1:0] mrd, logic mw);
    logic [2:0] ea [4];
    logic [2:0] eb [4];
    logic       es [4];
    id_rs1 = a; id_rs2 = b; ex_rd = erd; ex_wen = ew; ex_load = el;
    mem_rd = mrd; mem_wen = mw;
    #1;
    for (int p = 0; p < 4; p++) begin
      ea[p] = ref_op(p, a);
      eb[p] = ref_op(p, b);
      es[p] = ea[p][2] | eb[p][2];
      chk(st[p] == es[p], {req, " stall"}, p, st[p], es[p]);
      chk(bb[p] == es[p], "R10 bubble", p, bb[p], es[p]);
    end
    @(posedge clk); #1;
    for (int p = 0; p < 4; p++) begin
      chk(fa[p] == (es[p] ? 2'b00 : ea[p][1:0]), {req, " fwd_a"}, p, fa[p],
          es[p] ? 0 : ea[p][1:0]);
      chk(fb[p] == (es[p] ? 2'b00 : eb[p][1:0]), {req, " fwd_b"}, p, fb[p],
          es[p] ? 0 : eb[p][1:0]);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      chk(fa[p] == 0 && fb[p] == 0, "R1 reset", p, {fa[p], fb[p]}, 0);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int p = 0; p < 4; p++)
      chk(fa[p] == 0 && fb[p] == 0, "R1 after reset", p, {fa[p], fb[p]}, 0);
    @(negedge clk);
    // directed corners
    step("R6 alu dist1",  3, 4, 3, 1, 0, 9, 0);
    step("R6 load-use",   3, 4, 3, 1, 1, 9, 0);
    step("R6 after load", 3, 4, 0, 0, 0, 3, 1);   // bubble in ex, load in mem
    step("R8 dist2",      1, 6, 2, 1, 0, 6, 1);
    step("R5 both write", 5, 5, 5, 1, 0, 5, 1);
    step("R7 both load",  5, 2, 5, 1, 1, 5, 1);
    step("R3 zero src",   0, 0, 0, 1, 0, 0, 1);
    step("R4 no wen",     7, 7, 7, 0, 1, 7, 0);
    step("R9 dist mix",   2, 3, 2, 1, 0, 3, 1);
    // random traffic with small index range
    for (int i = 0; i < 400; i++) begin
      step("R2 random", RW'($urandom_range(0, 7)), RW'($urandom_range(0, 7)),
           RW'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
           RW'($urandom_range(0, 7)), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule